// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one channel of a periodic timer. A programmable up-counter advances at one of three divided rates of the block clock. When the counter equals a programmable constant at a counting step, it returns to zero and raises a match flag. When that constant is all ones in the active width, the clear is a roll-over, and an overflow flag is raised as well. Software can pick a 16-bit or a 32-bit counter width. It then polls the flags, or takes an interrupt from the match flag when the interrupt is enabled.

The channel sits on a small register bus with word addresses. Address 0 is control and status, address 1 is the counter and address 2 is the constant. Reads return data combinationally from the presented address. A write takes effect at the clock edge on which the write strobe is high. Each flag is sticky and can be cleared only by writing a zero to its bit.

Top module: `cmt_channel`

## Requirements
- R1: After synchronous reset, control/status reads 0x00000000, the counter reads 0x00000000, the constant reads 0xFFFFFFFF, and irq_o and ovf_o are low.
- R2: Address 0 holds the control/status word: bit 0 is run, bit 1 selects 16-bit width, bits 4:2 are the rate code, bit 5 is the interrupt enable, bit 7 is the match flag and bit 8 is the overflow flag. All other bits read zero. Address 1 is the counter, address 2 is the constant, and address 3 reads zero.
- R3: Rate code 000 advances the counter once every 8 cycles, 001 once every 32 cycles and 010 once every 128 cycles. The divider restarts when run goes high, so after the edge that sets run, N cycles pass before the first step.
- R4: Rate codes 011 through 111 produce no counting steps.
- R5: While run is 0 the counter keeps its value.
- R6: At a step where the counter equals the constant, the counter becomes 0 and the match flag is set.
- R7: The overflow flag is set only by a match while the constant is all ones in the active width. A match against any other constant leaves it clear.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to it leaves the flag unchanged.
- R9: If a flag is set by hardware on the same edge that software writes 0 to it, the flag ends up set.
- R10: In 16-bit mode, writes to the counter and constant store zero in bits 31:16, reads return zero there, and the counter wraps within 16 bits.
- R11: In 32-bit mode the counter carries past bit 15.
- R12: irq_o is high exactly while the match flag and the interrupt enable are both 1. ovf_o follows the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the divided rates |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Match interrupt request |
| ovf_o | output | 1 | Overflow flag level |

## Verification
The embedded properties assume that reset is held for at least one edge before any bus traffic. They also assume that the bus presents one access at a time, with the strobe and data stable across the edge. The stimulus drives every bus signal one time unit after a rising edge and keeps it steady until the next edge. The properties on the counter also assume that changing the width mode while a counter write is in flight is not meaningful. The bench therefore changes mode only while run is 0 and before it writes the counter or the constant.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CNT_W   = 32;
    localparam int HALF_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int N_RATES = 3;

    // log2 of each division ratio, indexed by rate code
    function automatic int tap_log(input int idx);
        case (idx)
            0:       return 3;
            1:       return 5;
            default: return 7;
        endcase
    endfunction

    localparam int PRE_W = tap_log(N_RATES - 1);

    typedef enum logic [2:0] {
        RATE_DIV8   = 3'b000,
        RATE_DIV32  = 3'b001,
        RATE_DIV128 = 3'b010
    } rate_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CONST = 2'd2,
        REG_NONE  = 2'd3
    } reg_e;

    // control/status word, LSB first: run, mode16, rate[2:0], ien, spare, match, ovf
    typedef struct packed {
        logic       ovf;
        logic       cmf;
        logic       spare;
        logic       ien;
        logic [2:0] rate;
        logic       mode16;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int CMF_BIT = 7;
    localparam int OVF_BIT = 8;

    function automatic logic [CNT_W-1:0] width_mask(input logic mode16);
        return mode16 ? {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {CNT_W{1'b1}};
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic [2:0] rate_i,
    output logic       tick_o
);

    logic [PRE_W-1:0]   pre_q;
    logic [N_RATES-1:0] taps;

    // free-running divider, held at zero while stopped so it restarts on run
    always_ff @(posedge clk) begin
        if (rst || !run_i)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    generate
        for (genvar g = 0; g < N_RATES; g++) begin : g_tap
            localparam int LG = tap_log(g);
            assign taps[g] = run_i && (&pre_q[LG-1:0]);
        end
    endgenerate

    always_comb begin
        case (rate_i)
            RATE_DIV8:   tick_o = taps[0];
            RATE_DIV32:  tick_o = taps[1];
            RATE_DIV128: tick_o = taps[2];
            default:     tick_o = 1'b0;
        endcase
    end

    // R3
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R5
    no_tick_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !tick_o);

    // R4
    no_tick_bad_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_i[2] || (rate_i[1] && rate_i[0])) |-> !tick_o);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode16_i,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic             const_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] const_o,
    output logic             match_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q, const_q, mask;
    logic             hit;

    assign mask    = width_mask(mode16_i);
    assign cnt_o   = cnt_q & mask;
    assign const_o = const_q & mask;

    // a bus write to the counter takes priority over a counting step
    assign hit     = tick_i && !cnt_wr_i && (cnt_o == const_o);
    assign match_o = hit;
    assign wrap_o  = hit && (const_o == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            const_q <= '1;
        end else begin
            if (cnt_wr_i)
                cnt_q <= wdata_i & mask;
            else if (hit)
                cnt_q <= '0;
            else if (tick_i)
                cnt_q <= (cnt_o + CNT_W'(1)) & mask;
            if (const_wr_i)
                const_q <= wdata_i & mask;
        end
    end

    // R6
    clear_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        match_o |=> (cnt_q == '0));

    // R5
    hold_without_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !cnt_wr_i) |=> $stable(cnt_q));

    // R10
    upper_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode16_i && cnt_wr_i) |=> (cnt_q[CNT_W-1:HALF_W] == '0));

endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // hardware set outranks a software clear on the same edge
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_q);

    // R8
    clear_by_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_q);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              ovf_o
);

    reg_e             sel;
    ctrl_t            ctrl_q, ctrl_view;
    logic             ctrl_wr, cnt_wr, const_wr;
    logic             tick, match, wrap, cmf, ovf;
    logic [CNT_W-1:0] cnt_val, const_val;

    assign sel      = reg_e'(bus_addr);
    assign ctrl_wr  = bus_wr && (sel == REG_CTRL);
    assign cnt_wr   = bus_wr && (sel == REG_COUNT);
    assign const_wr = bus_wr && (sel == REG_CONST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run    <= bus_wdata[0];
            ctrl_q.mode16 <= bus_wdata[1];
            ctrl_q.rate   <= bus_wdata[4:2];
            ctrl_q.ien    <= bus_wdata[5];
        end
    end

    cmt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctrl_q.run),
        .rate_i (ctrl_q.rate),
        .tick_o (tick)
    );

    cmt_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .mode16_i   (ctrl_q.mode16),
        .tick_i     (tick),
        .cnt_wr_i   (cnt_wr),
        .const_wr_i (const_wr),
        .wdata_i    (bus_wdata),
        .cnt_o      (cnt_val),
        .const_o    (const_val),
        .match_o    (match),
        .wrap_o     (wrap)
    );

    cmt_flag u_cmf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (match),
        .clr_i  (ctrl_wr && !bus_wdata[CMF_BIT]),
        .flag_o (cmf)
    );

    cmt_flag u_ovf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wrap),
        .clr_i  (ctrl_wr && !bus_wdata[OVF_BIT]),
        .flag_o (ovf)
    );

    always_comb begin
        ctrl_view       = ctrl_q;
        ctrl_view.spare = 1'b0;
        ctrl_view.cmf   = cmf;
        ctrl_view.ovf   = ovf;
        case (sel)
            REG_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_view};
            REG_COUNT: bus_rdata = cnt_val;
            REG_CONST: bus_rdata = const_val;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = cmf && ctrl_q.ien;
    assign ovf_o = ovf;

    // R7
    ovf_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(match));

    // R12
    irq_drop_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[5]) |=> !irq_o);

endmodule

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb_top;

    typedef struct {
        int          due;
        int          src;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, ovf_o;

    int       cyc = 0;
    int       n_cmp = 0;
    int       n_bad = 0;
    bit       done = 1'b0;
    sb_item_t sb_q[$];
    sb_item_t mon_item;
    logic [31:0] mon_act;

    cmt_channel dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .ovf_o     (ovf_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] cw(input bit run, input bit m16, input logic [2:0] rate,
                                       input bit ien, input bit cmf, input bit ovf);
        return {23'b0, ovf, cmf, 1'b0, ien, rate, m16, run};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // driver: present the address and push the expected read value
    task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        sb_q.push_back('{cyc, 0, e, tag});
    endtask

    // src 1 = irq_o, src 2 = ovf_o
    task automatic expect_pin(input int src, input bit e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{cyc, src, {31'b0, e}, tag});
    endtask

    // monitor: pop due items and compare against the outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            mon_item = sb_q.pop_front();
            case (mon_item.src)
                0:       mon_act = bus_rdata;
                1:       mon_act = {31'b0, irq_o};
                default: mon_act = {31'b0, ovf_o};
            endcase
            n_cmp++;
            if (mon_act !== mon_item.exp) begin
                n_bad++;
                $display("FAIL %s src=%0d actual=%h expected=%h", mon_item.tag,
                         mon_item.src, mon_act, mon_item.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        expect_reg(0, 32'h0, "R1");
        expect_reg(1, 32'h0, "R1");
        expect_reg(2, 32'hFFFF_FFFF, "R1");
        expect_pin(1, 1'b0, "R1");
        expect_pin(2, 1'b0, "R1");
        expect_reg(3, 32'h0, "R2");

        // R3 divide by 8: five steps by the 44th edge
        wr(2, 32'd1000);
        wr(0, cw(1, 0, 3'b000, 0, 1, 1));
        repeat (43) @(posedge clk);
        expect_reg(1, 32'd5, "R3");
        // R5 stopped counter holds
        wr(0, cw(0, 0, 3'b000, 0, 1, 1));
        repeat (200) @(posedge clk);
        expect_reg(1, 32'd5, "R5");
        expect_reg(0, cw(0, 0, 3'b000, 0, 0, 0), "R2");

        // R3 divide by 32
        wr(1, 32'd0);
        wr(0, cw(1, 0, 3'b001, 0, 1, 1));
        repeat (105) @(posedge clk);
        expect_reg(1, 32'd3, "R3");

        // R3 divide by 128
        wr(0, cw(0, 0, 3'b010, 0, 1, 1));
        wr(1, 32'd0);
        wr(0, cw(1, 0, 3'b010, 0, 1, 1));
        repeat (275) @(posedge clk);
        expect_reg(1, 32'd2, "R3");

        // R4 invalid rate codes
        wr(0, cw(0, 0, 3'b000, 0, 1, 1));
        wr(1, 32'd0);
        wr(0, cw(1, 0, 3'b011, 0, 1, 1));
        repeat (299) @(posedge clk);
        expect_reg(1, 32'd0, "R4");
        wr(0, cw(1, 0, 3'b111, 0, 1, 1));
        repeat (299) @(posedge clk);
        expect_reg(1, 32'd0, "R4");

        // R6/R9 match at the 32nd edge, coinciding with a clear write
        wr(0, cw(0, 0, 3'b000, 1, 1, 1));
        wr(1, 32'd0);
        wr(2, 32'd3);
        wr(0, cw(1, 0, 3'b000, 1, 1, 1));
        repeat (30) @(posedge clk);
        wr(0, cw(1, 0, 3'b000, 1, 0, 1));
        expect_reg(0, cw(1, 0, 3'b000, 1, 1, 0), "R9");
        expect_reg(1, 32'd0, "R6");
        expect_pin(1, 1'b1, "R12");

        // R8 write 1 keeps, write 0 clears
        wr(0, cw(0, 0, 3'b000, 1, 1, 1));
        expect_reg(0, cw(0, 0, 3'b000, 1, 1, 0), "R8");
        wr(0, cw(0, 0, 3'b000, 1, 0, 1));
        expect_reg(0, cw(0, 0, 3'b000, 1, 0, 0), "R8");
        expect_pin(1, 1'b0, "R8");

        // R10 16-bit writes and roll-over
        wr(0, cw(0, 1, 3'b000, 0, 1, 1));
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'h1234_FFFD);
        expect_reg(1, 32'h0000_FFFD, "R10");
        expect_reg(2, 32'h0000_FFFF, "R10");
        wr(0, cw(1, 1, 3'b000, 0, 1, 1));
        repeat (27) @(posedge clk);
        expect_reg(1, 32'd0, "R10");
        expect_reg(0, cw(1, 1, 3'b000, 0, 1, 1), "R7");
        expect_pin(2, 1'b1, "R12");
        expect_pin(1, 1'b0, "R12");
        wr(0, cw(0, 1, 3'b000, 0, 1, 0));
        expect_pin(2, 1'b0, "R8");

        // R11 32-bit carry past bit 15
        wr(0, cw(0, 0, 3'b000, 0, 0, 0));
        wr(2, 32'h0010_0000);
        wr(1, 32'h0000_FFFE);
        wr(0, cw(1, 0, 3'b000, 0, 1, 1));
        repeat (19) @(posedge clk);
        expect_reg(1, 32'h0001_0000, "R11");
        expect_pin(2, 1'b0, "R7");

        // R7 32-bit roll-over against all ones
        wr(0, cw(0, 0, 3'b000, 0, 0, 0));
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFE);
        wr(0, cw(1, 0, 3'b000, 0, 1, 1));
        repeat (19) @(posedge clk);
        expect_reg(1, 32'd0, "R7");
        expect_pin(2, 1'b1, "R7");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule